// File: doc/BRIEF.md
# Dual-Channel UART Host Bus Front End

This block sits between a host processor bus and the register sets of a two-channel UART. It turns chip-select, address and strobe activity into per-channel write strobes and returns read data from the selected channel. Two bus styles are supported, chosen by a static mode input. With the mode high, each channel has its own active-low select. With the mode low, one active-low select enables the device and a channel address bit picks the channel.

In the two-select style both channels can be selected at once. A write then updates the same register in both channels, which shortens start-up programming. A read with both channels selected is refused: it returns zero and raises an error flag. Each channel holds a small register bank: divisor low, divisor high, line control and scratchpad. When both divisor bytes of the addressed channel are zero and the host raises the identification qualifier, offsets 0 and 1 return a fixed identification code and a revision code instead.

Top module: `uhb_host_if`

## Requirements
- R1: With `bus_mode`=1, `sel_a_n` low alone selects channel A, `sel_b_n` low alone selects channel B, and both high selects nothing.
- R2: With `bus_mode`=0, `sel_a_n` is the only select and `sel_b_n` has no effect. While `sel_a_n` is high, no channel is selected whatever `chan_bit` holds. While it is low, `chan_bit`=0 selects A and `chan_bit`=1 selects B.
- R3: A write with both selects low in two-select mode updates the addressed register in both channels.
- R4: A read with both channels selected returns `rdata`=0x00 with `rd_err`=1 one clock after `rd_en`.
- R5: `rdata` is registered. It is valid one clock after `rd_en` and holds until the next read. `rd_err` is 0 on any read that does not select both channels. A read that selects no channel returns 0x00.
- R6: Offset 3 is line control and offset 7 is the scratchpad. Offsets 0 and 1 are divisor low and divisor high while line-control bit 7 is 1; while bit 7 is 0 they read 0x00 and ignore writes. Offsets 2, 4, 5 and 6 read 0x00 and ignore writes.
- R7: With `id_access`=1 and both divisor bytes of the addressed channel at 0x00, offset 0 reads 0x06 and offset 1 reads 0x01, whatever line-control bit 7 holds. If either divisor byte is nonzero, `id_access` has no effect.
- R8: A clock edge with `rst_n` low returns every register of both channels to 0x00.
- R9: A write leaves the register bank of every channel it does not select unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_mode | input | 1 | 1: two-select style, 0: single select with channel bit |
| sel_a_n | input | 1 | Channel A select (two-select style) or device select (single style), active low |
| sel_b_n | input | 1 | Channel B select, active low; ignored in single style |
| chan_bit | input | 1 | Channel pick in single style (0: A, 1: B) |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| id_access | input | 1 | Qualifier for identification/revision reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rd_err | output | 1 | Pulses high with data of a read that selected both channels |

## Verification
The hardest state to reach is the identification window. It needs the divisor-access bit set, both divisor bytes of one channel written to zero while the other channel keeps nonzero divisors, and then reads with the qualifier raised and the access bit both set and cleared. The stimulus first loads distinct divisors in each channel through individual writes. It clears one channel's divisors and reads both channels with the qualifier high. This shows that the codes appear only on the channel that meets the condition.

// File: rtl/uhb_pkg.sv
// Package: shared constants for the dual-channel host bus front end.
// Assumes an 8-bit or wider data bus and a 3-bit register offset.
package uhb_pkg;
    localparam int unsigned NUM_CH      = 2;
    localparam int unsigned DIV_ACC_BIT = 7;

    // Register offsets that carry storage
    localparam logic [2:0] OFS_DIV_LO  = 3'd0;
    localparam logic [2:0] OFS_DIV_HI  = 3'd1;
    localparam logic [2:0] OFS_LINE    = 3'd3;
    localparam logic [2:0] OFS_SCRATCH = 3'd7;

    // Fixed identification codes
    localparam logic [7:0] ID_CODE  = 8'h06;
    localparam logic [7:0] REV_CODE = 8'h01;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_DUAL   = 1'b1
    } bus_style_e;
endpackage

// File: rtl/uhb_sel_decode.sv
// Module: uhb_sel_decode
// Turns the chip-select pins into a per-channel select vector.
// Assumes bus_mode is static during operation. Purely combinational.
module uhb_sel_decode
    import uhb_pkg::*;
(
    input  logic              bus_mode,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              chan_bit,
    output logic [NUM_CH-1:0] chan_sel
);
    // Decode the active bus style into channel selects
    always_comb begin
        if (bus_style_e'(bus_mode) == MODE_DUAL) begin
            chan_sel[0] = ~sel_a_n;
            chan_sel[1] = ~sel_b_n;
        end else begin
            chan_sel[0] = ~sel_a_n & ~chan_bit;
            chan_sel[1] = ~sel_a_n &  chan_bit;
        end
    end
endmodule

// File: rtl/uhb_chan_regs.sv
// Module: uhb_chan_regs
// One channel's register bank: divisor low/high, line control, scratchpad.
// Produces combinational read data, including the ID/revision window.
// Assumes DATA_W >= 8 and that wr_stb is already qualified by channel select.
module uhb_chan_regs
    import uhb_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              id_access,
    output logic [DATA_W-1:0] rd_val,
    output logic              div_zero
);
    localparam logic [DATA_W-1:0] ZERO_W = '0;

    logic [DATA_W-1:0] div_lo_q;
    logic [DATA_W-1:0] div_hi_q;
    logic [DATA_W-1:0] line_q;
    logic [DATA_W-1:0] scratch_q;
    logic              div_open;
    logic              id_hit;

    assign div_open = line_q[DIV_ACC_BIT];
    assign div_zero = (div_lo_q == ZERO_W) && (div_hi_q == ZERO_W);
    assign id_hit   = id_access && div_zero;

    // Register writes with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lo_q  <= ZERO_W;
            div_hi_q  <= ZERO_W;
            line_q    <= ZERO_W;
            scratch_q <= ZERO_W;
        end else if (wr_stb) begin
            case (addr)
                ADDR_W'(OFS_DIV_LO):  if (div_open) div_lo_q <= wdata;
                ADDR_W'(OFS_DIV_HI):  if (div_open) div_hi_q <= wdata;
                ADDR_W'(OFS_LINE):    line_q    <= wdata;
                ADDR_W'(OFS_SCRATCH): scratch_q <= wdata;
                default: ;
            endcase
        end
    end

    // Read-side decode of the register offset
    always_comb begin
        rd_val = ZERO_W;
        case (addr)
            ADDR_W'(OFS_DIV_LO):
                if (id_hit)        rd_val = DATA_W'(ID_CODE);
                else if (div_open) rd_val = div_lo_q;
            ADDR_W'(OFS_DIV_HI):
                if (id_hit)        rd_val = DATA_W'(REV_CODE);
                else if (div_open) rd_val = div_hi_q;
            ADDR_W'(OFS_LINE):    rd_val = line_q;
            ADDR_W'(OFS_SCRATCH): rd_val = scratch_q;
            default:              rd_val = ZERO_W;
        endcase
    end

    // R9
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(div_lo_q) && $stable(div_hi_q) && $stable(line_q) && $stable(scratch_q)));

    // R8
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (div_lo_q == ZERO_W && div_hi_q == ZERO_W && line_q == ZERO_W && scratch_q == ZERO_W));

    // R6
    scratch_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr == ADDR_W'(OFS_SCRATCH)) |=> (scratch_q == $past(wdata)));

    // R6
    div_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !div_open && addr != ADDR_W'(OFS_LINE)) |=> ($stable(div_lo_q) && $stable(div_hi_q)));
endmodule

// File: rtl/uhb_rd_port.sv
// Module: uhb_rd_port
// Registers read data from the selected channel. A read that selects more
// than one channel returns zero and pulses the error flag.
// Assumes rd_en is a single-cycle strobe.
module uhb_rd_port #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NUM_CH = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [NUM_CH-1:0]              chan_sel,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  ch_val,
    output logic [DATA_W-1:0]              rdata,
    output logic                           rd_err
);
    logic [DATA_W-1:0] pick;
    logic              multi;

    // Gather the value of the single selected channel
    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (chan_sel[i]) pick = pick | ch_val[i];
        end
        multi = ($countones(chan_sel) > 1);
    end

    // Capture read data and the conflict flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rd_err <= 1'b0;
        end else if (rd_en) begin
            rdata  <= multi ? '0 : pick;
            rd_err <= multi;
        end else begin
            rd_err <= 1'b0;
        end
    end

    // R4
    multi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $countones(chan_sel) > 1) |=> (rdata == '0 && rd_err));

    // R5
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(rdata) && !rd_err));

    // R5
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && chan_sel == '0) |=> (rdata == '0 && !rd_err));
endmodule

// File: rtl/uhb_host_if.sv
// Module: uhb_host_if
// Host bus front end for a two-channel UART register set. Decodes the
// chip selects, fans writes out to one or both channel banks, and returns
// registered read data. Assumes bus_mode is tied off and strobes last one cycle.
module uhb_host_if
    import uhb_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_mode,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              chan_bit,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              id_access,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_err
);
    logic [NUM_CH-1:0]             chan_sel;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_val;
    logic [NUM_CH-1:0]             ch_div_zero;

    uhb_sel_decode u_dec (
        .bus_mode (bus_mode),
        .sel_a_n  (sel_a_n),
        .sel_b_n  (sel_b_n),
        .chan_bit (chan_bit),
        .chan_sel (chan_sel)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic wr_stb;
        // Qualify the write strobe with this channel's select
        assign wr_stb = wr_en & chan_sel[c];

        uhb_chan_regs #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W)
        ) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_stb    (wr_stb),
            .addr      (addr),
            .wdata     (wdata),
            .id_access (id_access),
            .rd_val    (ch_val[c]),
            .div_zero  (ch_div_zero[c])
        );
    end

    uhb_rd_port #(
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .chan_sel (chan_sel),
        .ch_val   (ch_val),
        .rdata    (rdata),
        .rd_err   (rd_err)
    );

    // R2
    single_style_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode == 1'b0) |-> $onehot0(chan_sel));

    // R2
    single_style_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode == 1'b0 && sel_a_n && rd_en) |=> (rdata == '0 && !rd_err));

    // R7
    id_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && chan_sel == 2'b01 && id_access && ch_div_zero[0] && addr == ADDR_W'(OFS_DIV_LO))
        |=> (rdata == DATA_W'(ID_CODE)));

    // R7
    rev_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && chan_sel == 2'b10 && id_access && ch_div_zero[1] && addr == ADDR_W'(OFS_DIV_HI))
        |=> (rdata == DATA_W'(REV_CODE)));
endmodule

// File: tb/sim_uhb_host_if.sv
// Scoreboard bench: driver tasks push expected read results into queues;
// a monitor pops and compares them one clock after each read strobe.
module sim_uhb_host_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_mode = 1'b1;
    logic       sel_a_n = 1'b1;
    logic       sel_b_n = 1'b1;
    logic       chan_bit = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       id_access = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rd_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state
    logic [7:0] m_dl [2];
    logic [7:0] m_dh [2];
    logic [7:0] m_lc [2];
    logic [7:0] m_sp [2];

    // Expected-item queues
    logic [7:0] q_d [$];
    logic       q_e [$];
    string      q_t [$];
    logic       mon_due = 1'b0;

    always #2.5 clk = ~clk;

    uhb_host_if u0 (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .sel_a_n(sel_a_n),
        .sel_b_n(sel_b_n), .chan_bit(chan_bit), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .id_access(id_access), .wdata(wdata),
        .rdata(rdata), .rd_err(rd_err)
    );

    function automatic logic [1:0] sel_of(input logic md, input logic sa, input logic sb, input logic cb);
        if (md) return {~sb, ~sa};
        return {~sa & cb, ~sa & ~cb};
    endfunction

    function automatic logic [7:0] reg_of(input int c, input logic [2:0] ad, input logic idq);
        if (idq && m_dl[c] == 8'h00 && m_dh[c] == 8'h00 && ad == 3'd0) return 8'h06;
        if (idq && m_dl[c] == 8'h00 && m_dh[c] == 8'h00 && ad == 3'd1) return 8'h01;
        case (ad)
            3'd0: return m_lc[c][7] ? m_dl[c] : 8'h00;
            3'd1: return m_lc[c][7] ? m_dh[c] : 8'h00;
            3'd3: return m_lc[c];
            3'd7: return m_sp[c];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_dl[c] = 8'h00; m_dh[c] = 8'h00; m_lc[c] = 8'h00; m_sp[c] = 8'h00;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    task automatic bus_wr(input logic md, input logic sa, input logic sb, input logic cb,
                          input logic [2:0] ad, input logic [7:0] d);
        logic [1:0] s;
        s = sel_of(md, sa, sb, cb);
        @(negedge clk);
        bus_mode = md; sel_a_n = sa; sel_b_n = sb; chan_bit = cb;
        addr = ad; wdata = d; wr_en = 1'b1;
        for (int c = 0; c < 2; c++) begin
            if (s[c]) begin
                case (ad)
                    3'd0: if (m_lc[c][7]) m_dl[c] = d;
                    3'd1: if (m_lc[c][7]) m_dh[c] = d;
                    3'd3: m_lc[c] = d;
                    3'd7: m_sp[c] = d;
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        wr_en = 1'b0; sel_a_n = 1'b1; sel_b_n = 1'b1;
    endtask

    task automatic bus_rd(input logic md, input logic sa, input logic sb, input logic cb,
                          input logic [2:0] ad, input logic idq, input string tag);
        logic [1:0] s;
        s = sel_of(md, sa, sb, cb);
        @(negedge clk);
        bus_mode = md; sel_a_n = sa; sel_b_n = sb; chan_bit = cb;
        addr = ad; id_access = idq; rd_en = 1'b1;
        if (s == 2'b11) begin
            q_d.push_back(8'h00); q_e.push_back(1'b1);
        end else if (s == 2'b01) begin
            q_d.push_back(reg_of(0, ad, idq)); q_e.push_back(1'b0);
        end else if (s == 2'b10) begin
            q_d.push_back(reg_of(1, ad, idq)); q_e.push_back(1'b0);
        end else begin
            q_d.push_back(8'h00); q_e.push_back(1'b0);
        end
        q_t.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0; id_access = 1'b0; sel_a_n = 1'b1; sel_b_n = 1'b1;
    endtask

    // Note that a read strobe was sampled at this edge
    always @(posedge clk) mon_due <= rd_en;

    // Compare the captured read result with the scoreboard head
    always @(negedge clk) begin
        if (mon_due && !done) begin
            if (q_d.size() == 0) begin
                checks++; fails++;
                $display("FAIL R5: unexpected read result rdata=%h err=%b (expected none)", rdata, rd_err);
            end else begin
                logic [7:0] ed;
                logic       ee;
                string      et;
                ed = q_d.pop_front(); ee = q_e.pop_front(); et = q_t.pop_front();
                checks++;
                if (rdata !== ed || rd_err !== ee) begin
                    fails++;
                    $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b", et, rdata, rd_err, ed, ee);
                end
            end
        end
    end

    task automatic report();
        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish (expected completion)");
        report();
    end

    initial begin
        model_reset();
        do_reset();
        // R8 reset state
        bus_rd(1, 0, 1, 0, 3'd3, 0, "R8 lc A");
        bus_rd(1, 1, 0, 0, 3'd7, 0, "R8 sp B");

        // R1 individual selects in two-select mode, R6 register map
        bus_wr(1, 0, 1, 0, 3'd3, 8'h80);
        bus_wr(1, 1, 0, 0, 3'd3, 8'h80);
        bus_wr(1, 0, 1, 0, 3'd0, 8'h12);
        bus_wr(1, 0, 1, 0, 3'd1, 8'h34);
        bus_wr(1, 1, 0, 0, 3'd0, 8'h56);
        bus_wr(1, 1, 0, 0, 3'd1, 8'h78);
        bus_wr(1, 0, 1, 0, 3'd7, 8'hA5);
        bus_wr(1, 1, 0, 0, 3'd7, 8'h5A);
        bus_rd(1, 0, 1, 0, 3'd0, 0, "R1 R6 dl A");
        bus_rd(1, 0, 1, 0, 3'd1, 0, "R1 R6 dh A");
        bus_rd(1, 1, 0, 0, 3'd0, 0, "R1 R6 dl B");
        bus_rd(1, 1, 0, 0, 3'd1, 0, "R1 R6 dh B");
        bus_rd(1, 0, 1, 0, 3'd7, 0, "R1 sp A");
        bus_rd(1, 1, 0, 0, 3'd7, 0, "R1 sp B");

        // R9 deselected write, R5 deselected read
        bus_wr(1, 1, 1, 0, 3'd7, 8'hFF);
        bus_rd(1, 0, 1, 0, 3'd7, 0, "R9 sp A");
        bus_rd(1, 1, 0, 0, 3'd7, 0, "R9 sp B");
        bus_rd(1, 1, 1, 0, 3'd7, 0, "R5 idle read");

        // R3 broadcast write
        bus_wr(1, 0, 0, 0, 3'd7, 8'h3C);
        bus_wr(1, 0, 0, 0, 3'd3, 8'h83);
        bus_rd(1, 0, 1, 0, 3'd7, 0, "R3 sp A");
        bus_rd(1, 1, 0, 0, 3'd7, 0, "R3 sp B");
        bus_rd(1, 0, 1, 0, 3'd3, 0, "R3 lc A");
        bus_rd(1, 1, 0, 0, 3'd3, 0, "R3 lc B");

        // R4 dual read, then R5 flag clears and data holds
        bus_rd(1, 0, 0, 0, 3'd7, 0, "R4 dual read");
        bus_rd(1, 0, 1, 0, 3'd0, 0, "R5 single after dual");
        repeat (3) @(negedge clk);
        checks++;
        if (rdata !== 8'h12 || rd_err !== 1'b0) begin
            fails++;
            $display("FAIL R5: hold rdata=%h err=%b expected rdata=12 err=0", rdata, rd_err);
        end

        // R2 single-select style
        bus_wr(0, 1, 1, 0, 3'd7, 8'h11);
        bus_wr(0, 1, 1, 1, 3'd7, 8'h11);
        bus_wr(0, 1, 0, 0, 3'd7, 8'h11);
        bus_rd(0, 0, 1, 0, 3'd7, 0, "R2 cs high ignored A");
        bus_rd(0, 0, 1, 1, 3'd7, 0, "R2 cs high ignored B");
        bus_wr(0, 0, 1, 0, 3'd7, 8'h21);
        bus_wr(0, 0, 0, 1, 3'd7, 8'h42);
        bus_rd(0, 0, 1, 0, 3'd7, 0, "R2 pick A");
        bus_rd(0, 0, 0, 1, 3'd7, 0, "R2 pick B with sel_b low");
        bus_rd(0, 1, 0, 1, 3'd7, 0, "R2 cs high read");
        bus_rd(1, 0, 1, 0, 3'd7, 0, "R2 A via two-select");

        // R6 unused offsets and divisor gating
        for (int o = 2; o < 7; o++) begin
            if (o != 3) begin
                bus_wr(1, 0, 0, 0, 3'(o), 8'hEE);
                bus_rd(1, 0, 1, 0, 3'(o), 0, "R6 unused offset");
            end
        end
        bus_wr(1, 0, 1, 0, 3'd3, 8'h03);
        bus_rd(1, 0, 1, 0, 3'd0, 0, "R6 div hidden");
        bus_wr(1, 0, 1, 0, 3'd0, 8'h99);
        bus_wr(1, 0, 1, 0, 3'd3, 8'h83);
        bus_rd(1, 0, 1, 0, 3'd0, 0, "R6 div locked");

        // R7 identification window
        bus_rd(1, 0, 1, 0, 3'd0, 1, "R7 nonzero div A");
        bus_wr(1, 0, 1, 0, 3'd0, 8'h00);
        bus_rd(1, 0, 1, 0, 3'd0, 1, "R7 half zero A");
        bus_wr(1, 0, 1, 0, 3'd1, 8'h00);
        bus_rd(1, 0, 1, 0, 3'd0, 1, "R7 id A");
        bus_rd(1, 0, 1, 0, 3'd1, 1, "R7 rev A");
        bus_rd(1, 1, 0, 0, 3'd0, 1, "R7 B untouched");
        bus_wr(1, 0, 1, 0, 3'd3, 8'h03);
        bus_rd(1, 0, 1, 0, 3'd0, 1, "R7 id A lcr7 clear");
        bus_rd(1, 0, 1, 0, 3'd0, 0, "R7 no qualifier");

        // R8 reset clears everything
        do_reset();
        bus_rd(1, 1, 0, 0, 3'd3, 0, "R8 lc B");
        bus_rd(1, 0, 1, 0, 3'd7, 0, "R8 sp A");
        bus_rd(1, 1, 0, 0, 3'd0, 1, "R8 id B after reset");

        repeat (3) @(negedge clk);
        checks++;
        if (q_d.size() != 0) begin
            fails++;
            $display("FAIL R5: %0d reads without result (expected 0)", q_d.size());
        end
        report();
    end
endmodule